// File: doc/BRIEF.md
# AC'97 Codec Register Access Engine

This block carries host register reads and writes to an external AC'97 codec. The host loads a command-data word and then a command-address word into two transmit registers. At the next frame strobe from the link, the engine places them in the command slots of the outgoing frame. For a read, it watches the status slots of later incoming frames. It accepts a response only when both status slots are present and the echoed register index matches the pending request. The data is then held in two receive registers, each with its own valid flag.

A small register window gives the host access to everything it needs: slot enables, codec selection, the transmit and receive words, a flag word, and a cold-reset trigger. The engine drives the codec select lines and an active-low cold reset. That reset is asserted for a fixed number of clocks at power-up and on request. The link counts as ready once the reset is released and a set number of frames has passed.

Top module: `ac97_cmd_engine`

## Requirements
- R1: While `rst_n` is low and on the first sample after it rises, `codec_rst_n` is 0, `tx_tag1` and `tx_tag2` are 0, and the flag word (address 5) reads 0x40. Flag word bits: 0 slot-1 busy, 1 slot-2 busy, 2 slot-1 valid, 3 slot-2 valid, 4 index mismatch, 5 link ready, 6 cold reset active.
- R2: `codec_rst_n` stays low for `RST_CYCLES` clocks after `rst_n` rises, and for the same count after the host writes 1 to bit 0 at address 6. Link ready (flag bit 5) is set only after `WAKE_FRAMES` frame strobes have followed the release.
- R3: A word written to the slot-1 transmit register (address 1) keeps bits 19:12 and clears bits 11:0. Bit 19 is the read flag and bits 18:12 are the register index. A word written to the slot-2 transmit register (address 2) keeps bits 19:4 and clears bits 3:0.
- R4: Loading a transmit register sets its busy flag. The flag clears only at the frame strobe that sends that slot.
- R5: A slot-2 word is sent only in the same frame as a committed slot-1 word, so a slot-2 load alone is held. `tx_tag2` is never 1 unless `tx_tag1` is 1.
- R6: While a transmit enable bit is clear, that slot is not sent and its busy flag stays set. Control word (address 0) bits: 0 slot-1 tx enable, 1 slot-2 tx enable, 2 slot-1 rx enable, 3 slot-2 rx enable, 6:4 codec index.
- R7: After a read request has been sent, a frame strobe with both receive tags and a matching echoed index (bits 18:12 of `rx_slot1`) sets both valid flags together. The receive registers at addresses 3 and 4 then hold the status words, masked as in R3. A host read of either receive register clears that register's valid flag.
- R8: A response whose echoed index differs from the request sets the mismatch flag. It leaves the valid flags and receive registers unchanged and keeps the request pending. A later matching response is accepted and clears the mismatch flag.
- R9: Writing codec index 0 to 3 drives that value on `codec_sel`. Writing an index of 4 or more leaves `codec_sel` unchanged.
- R10: While either receive enable bit is clear, a response is not captured and the read stays pending.
- R11: The transmit outputs change only on the clock after a frame strobe. A frame with nothing committed drives both tags to 0, and the slot words keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (clears valid on receive registers) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 20 | Write data |
| host_rdata | output | 20 | Read data for `host_addr` |
| frame_sync | input | 1 | One-clock frame boundary strobe |
| rx_slot1 | input | 20 | Incoming status-address slot |
| rx_slot2 | input | 20 | Incoming status-data slot |
| rx_tag1 | input | 1 | Incoming slot 1 carries data |
| rx_tag2 | input | 1 | Incoming slot 2 carries data |
| tx_slot1 | output | 20 | Outgoing command-address slot |
| tx_slot2 | output | 20 | Outgoing command-data slot |
| tx_tag1 | output | 1 | Outgoing slot 1 valid this frame |
| tx_tag2 | output | 1 | Outgoing slot 2 valid this frame |
| codec_sel | output | 2 | Selected codec |
| codec_rst_n | output | 1 | Active-low codec cold reset |

## Verification
The bench targets the ordering rule: a data word loaded alone must wait for its address word. A design that sent it early would raise `tx_tag2` in a frame without `tx_tag1`. It also feeds a response with a wrong echoed index. A design without tag matching would then report valid data for the wrong register, or lose the pending request so that the correct retry is never accepted. The bench checks disabled slot enables: a leaky design would send the word or drop it with busy cleared. Finally, it writes out-of-range codec indices, which a truncating design would wrap onto `codec_sel`, and it counts the exact length of the cold-reset pulse.

// File: rtl/ac97_cmd_engine.sv
module ac97_cmd_engine #(
  parameter int RST_CYCLES  = 100,
  parameter int WAKE_FRAMES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic        host_re,
  input  logic [2:0]  host_addr,
  input  logic [19:0] host_wdata,
  output logic [19:0] host_rdata,
  input  logic        frame_sync,
  input  logic [19:0] rx_slot1,
  input  logic [19:0] rx_slot2,
  input  logic        rx_tag1,
  input  logic        rx_tag2,
  output logic [19:0] tx_slot1,
  output logic [19:0] tx_slot2,
  output logic        tx_tag1,
  output logic        tx_tag2,
  output logic [1:0]  codec_sel,
  output logic        codec_rst_n
);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam int WW = $clog2(WAKE_FRAMES + 1);
  localparam logic [2:0] A_CTL = 3'd0, A_TX1 = 3'd1, A_TX2 = 3'd2,
                         A_RX1 = 3'd3, A_RX2 = 3'd4, A_FLG = 3'd5, A_RST = 3'd6;

  logic [3:0]  en;
  logic [19:0] cmd_addr, cmd_data, sts_addr, sts_data;
  logic        busy1, busy2, vld1, vld2, mism, pend;
  logic [6:0]  pend_idx;
  logic [RW-1:0] rst_cnt;
  logic [WW-1:0] wake_cnt;
  logic        link_ready;

  wire wr_ctl = host_we && host_addr == A_CTL;
  wire ld1    = host_we && host_addr == A_TX1;
  wire ld2    = host_we && host_addr == A_TX2;
  wire kick   = host_we && host_addr == A_RST && host_wdata[0];
  wire send1  = frame_sync && busy1 && en[0];
  wire send2  = send1 && busy2 && en[1];
  wire rx_try = frame_sync && rx_tag1 && rx_tag2 && en[2] && en[3] && pend && !busy1;
  wire rx_ok  = rx_slot1[18:12] == pend_idx;

  assign codec_rst_n = rst_cnt == '0;
  assign link_ready  = codec_rst_n && wake_cnt == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0; codec_sel <= '0;
      cmd_addr <= '0; cmd_data <= '0; sts_addr <= '0; sts_data <= '0;
      busy1 <= 1'b0; busy2 <= 1'b0; vld1 <= 1'b0; vld2 <= 1'b0;
      mism <= 1'b0; pend <= 1'b0; pend_idx <= '0;
      tx_slot1 <= '0; tx_slot2 <= '0; tx_tag1 <= 1'b0; tx_tag2 <= 1'b0;
      rst_cnt <= RW'(RST_CYCLES); wake_cnt <= WW'(WAKE_FRAMES);
    end else begin
      if (frame_sync) begin
        tx_tag1 <= send1;
        tx_tag2 <= send2;
      end
      if (send1) begin tx_slot1 <= cmd_addr; busy1 <= 1'b0; end
      if (send2) begin tx_slot2 <= cmd_data; busy2 <= 1'b0; end
      if (ld1) begin
        cmd_addr <= {host_wdata[19:12], 12'h000};
        busy1    <= 1'b1;
        pend     <= host_wdata[19];
        pend_idx <= host_wdata[18:12];
        mism     <= 1'b0;
      end
      if (ld2) begin
        cmd_data <= {host_wdata[19:4], 4'h0};
        busy2    <= 1'b1;
      end
      if (host_re && host_addr == A_RX1) vld1 <= 1'b0;
      if (host_re && host_addr == A_RX2) vld2 <= 1'b0;
      if (rx_try) begin
        if (rx_ok) begin
          sts_addr <= {rx_slot1[19:12], 12'h000};
          sts_data <= {rx_slot2[19:4], 4'h0};
          vld1 <= 1'b1; vld2 <= 1'b1; mism <= 1'b0; pend <= 1'b0;
        end else begin
          mism <= 1'b1;
        end
      end
      if (wr_ctl) begin
        en <= host_wdata[3:0];
        if (host_wdata[6:4] < 3'd4) codec_sel <= host_wdata[5:4];
      end
      if (kick) begin
        rst_cnt  <= RW'(RST_CYCLES);
        wake_cnt <= WW'(WAKE_FRAMES);
      end else if (rst_cnt != '0) begin
        rst_cnt <= rst_cnt - 1'b1;
      end else if (frame_sync && wake_cnt != '0) begin
        wake_cnt <= wake_cnt - 1'b1;
      end
    end
  end

  always_comb begin
    case (host_addr)
      A_CTL:   host_rdata = {14'h0, codec_sel, en};
      A_TX1:   host_rdata = cmd_addr;
      A_TX2:   host_rdata = cmd_data;
      A_RX1:   host_rdata = sts_addr;
      A_RX2:   host_rdata = sts_data;
      A_FLG:   host_rdata = {13'h0, !codec_rst_n, link_ready, mism, vld2, vld1, busy2, busy1};
      A_RST:   host_rdata = {19'h0, !codec_rst_n};
      default: host_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{host_wdata[11:7], rx_slot1[11:0], rx_slot2[3:0]};

  AST_TAG2_NEEDS_TAG1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tag2 |-> tx_tag1); // R5
  AST_TX_ONLY_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_sync) |-> ($stable(tx_tag1) && $stable(tx_slot1))); // R11
  AST_BUSY_FALLS_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy1) |-> $past(frame_sync)); // R4
  AST_VALID_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld1) |-> vld2); // R7
  AST_NO_VALID_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mism) |-> !$rose(vld1)); // R8
  AST_NOT_READY_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !codec_rst_n |-> !link_ready); // R2
endmodule

// File: tb/test_ac97_cmd_engine.sv
module test_ac97_cmd_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 0, host_re = 0;
  logic [2:0] host_addr = 0;
  logic [19:0] host_wdata = 0, host_rdata;
  logic frame_sync = 0, rx_tag1 = 0, rx_tag2 = 0;
  logic [19:0] rx_slot1 = 0, rx_slot2 = 0, tx_slot1, tx_slot2;
  logic tx_tag1, tx_tag2, codec_rst_n;
  logic [1:0] codec_sel;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ac97_cmd_engine i_ac97_cmd_engine (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .frame_sync(frame_sync), .rx_slot1(rx_slot1), .rx_slot2(rx_slot2),
    .rx_tag1(rx_tag1), .rx_tag2(rx_tag2), .tx_slot1(tx_slot1), .tx_slot2(tx_slot2),
    .tx_tag1(tx_tag1), .tx_tag2(tx_tag2), .codec_sel(codec_sel), .codec_rst_n(codec_rst_n));

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic clr, output logic [19:0] d);
    @(negedge clk); host_addr = a; host_re = clr; #1 d = host_rdata;
    @(negedge clk); host_re = 0;
  endtask

  task automatic frame(input logic t1, input logic t2, input logic [19:0] s1, input logic [19:0] s2);
    @(negedge clk); frame_sync = 1; rx_tag1 = t1; rx_tag2 = t2; rx_slot1 = s1; rx_slot2 = s2;
    @(negedge clk); frame_sync = 0; rx_tag1 = 0; rx_tag2 = 0;
  endtask

  task automatic chk_flags(input string req, input logic [19:0] exp);
    logic [19:0] v;
    rd(3'd5, 1'b0, v);
    check(req, v, exp);
  endtask

  task automatic t_reset_and_wake();
    @(negedge clk); rst_n = 1;
    check("R1 codec_rst_n", {19'h0, codec_rst_n}, 20'h0);
    check("R1 tags", {18'h0, tx_tag2, tx_tag1}, 20'h0);
    host_addr = 3'd5; #1 check("R1 flags", host_rdata, 20'h40);
    repeat (99) @(negedge clk);
    check("R2 still low", {19'h0, codec_rst_n}, 20'h0);
    @(negedge clk);
    check("R2 released", {19'h0, codec_rst_n}, 20'h1);
    frame(0, 0, 0, 0);
    chk_flags("R2 not ready after one frame", 20'h00);
    frame(0, 0, 0, 0);
    chk_flags("R2 ready", 20'h20);
  endtask

  task automatic t_write();
    logic [19:0] v;
    wr(3'd0, 20'h0000F);
    wr(3'd2, 20'h12345);
    rd(3'd2, 1'b0, v); check("R3 slot2 mask", v, 20'h12340);
    wr(3'd1, 20'h2A3FF);
    rd(3'd1, 1'b0, v); check("R3 slot1 mask", v, 20'h2A000);
    chk_flags("R4 busy set", 20'h23);
    frame(0, 0, 0, 0);
    check("R4 tags", {18'h0, tx_tag2, tx_tag1}, 20'h3);
    check("R4 slot1 out", tx_slot1, 20'h2A000);
    check("R4 slot2 out", tx_slot2, 20'h12340);
    chk_flags("R4 busy clear", 20'h20);
    frame(0, 0, 0, 0);
    check("R11 idle tags", {18'h0, tx_tag2, tx_tag1}, 20'h0);
    check("R11 slot held", tx_slot1, 20'h2A000);
  endtask

  task automatic t_order();
    wr(3'd2, 20'hABCD0);
    frame(0, 0, 0, 0);
    check("R5 slot2 alone held", {18'h0, tx_tag2, tx_tag1}, 20'h0);
    chk_flags("R5 slot2 still busy", 20'h22);
    wr(3'd1, 20'h05000);
    frame(0, 0, 0, 0);
    check("R5 sent together", {18'h0, tx_tag2, tx_tag1}, 20'h3);
    check("R5 slot2 data", tx_slot2, 20'hABCD0);
  endtask

  task automatic t_enable();
    wr(3'd0, 20'h0000E);
    wr(3'd1, 20'h07000);
    frame(0, 0, 0, 0);
    check("R6 disabled not sent", {19'h0, tx_tag1}, 20'h0);
    chk_flags("R6 busy kept", 20'h21);
    wr(3'd0, 20'h0000F);
    frame(0, 0, 0, 0);
    check("R6 sent after enable", {19'h0, tx_tag1}, 20'h1);
    check("R6 slot1", tx_slot1, 20'h07000);
  endtask

  task automatic t_read();
    logic [19:0] v;
    wr(3'd1, 20'hA6000);
    frame(0, 0, 0, 0);
    frame(1, 1, 20'h26123, 20'hBEEF7);
    chk_flags("R7 both valid", 20'h2C);
    rd(3'd4, 1'b1, v); check("R7 read data", v, 20'hBEEF0);
    chk_flags("R7 slot2 valid cleared", 20'h24);
    rd(3'd3, 1'b1, v); check("R7 echo addr", v, 20'h26000);
    chk_flags("R7 all clear", 20'h20);
  endtask

  task automatic t_mismatch();
    logic [19:0] v;
    wr(3'd1, 20'h91000);
    frame(0, 0, 0, 0);
    frame(1, 1, 20'h12000, 20'h55550);
    chk_flags("R8 mismatch flagged", 20'h30);
    rd(3'd4, 1'b0, v); check("R8 stale data kept", v, 20'hBEEF0);
    frame(1, 1, 20'h11000, 20'h44440);
    chk_flags("R8 retry accepted", 20'h2C);
    rd(3'd4, 1'b1, v); check("R8 retry data", v, 20'h44440);
    rd(3'd3, 1'b1, v);
  endtask

  task automatic t_rx_enable();
    logic [19:0] v;
    wr(3'd0, 20'h0000B);
    wr(3'd1, 20'h93000);
    frame(0, 0, 0, 0);
    frame(1, 1, 20'h13000, 20'h77770);
    chk_flags("R10 not captured", 20'h20);
    wr(3'd0, 20'h0000F);
    frame(1, 1, 20'h13000, 20'h77770);
    chk_flags("R10 captured after enable", 20'h2C);
    rd(3'd4, 1'b1, v); check("R10 data", v, 20'h77770);
    rd(3'd3, 1'b1, v);
  endtask

  task automatic t_select();
    wr(3'd0, 20'h0002F);
    check("R9 sel 2", {18'h0, codec_sel}, 20'h2);
    wr(3'd0, 20'h0004F);
    check("R9 index 4 rejected", {18'h0, codec_sel}, 20'h2);
    wr(3'd0, 20'h0007F);
    check("R9 index 7 rejected", {18'h0, codec_sel}, 20'h2);
    wr(3'd0, 20'h0003F);
    check("R9 sel 3", {18'h0, codec_sel}, 20'h3);
  endtask

  task automatic t_cold_reset();
    wr(3'd6, 20'h00001);
    check("R2 reset asserted", {19'h0, codec_rst_n}, 20'h0);
    chk_flags("R2 reset flags", 20'h40);
    repeat (97) @(negedge clk);
    check("R2 pulse length", {19'h0, codec_rst_n}, 20'h0);
    @(negedge clk);
    check("R2 pulse end", {19'h0, codec_rst_n}, 20'h1);
    frame(0, 0, 0, 0); frame(0, 0, 0, 0);
    chk_flags("R2 ready again", 20'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_and_wake();
    t_write();
    t_order();
    t_enable();
    t_read();
    t_mismatch();
    t_rx_enable();
    t_select();
    t_cold_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule